// File: doc/BRIEF.md
# Fallback Boot Image Selector

This block sequences device configuration after a power-on reset or a reconfiguration request. It first reads a serial flash to find a decision record. Four copies of the record sit at fixed offsets, and the block uses the first one that is valid. From that record it takes the factory image address and a list of up to eight application image pointers.

Unless a force-factory input is high, the block walks the pointer list from the last entry down to the first. It hands each image address to an external loader and waits for the loader to report done or fail. Each failure produces a fixed-length active-low pulse on the status output, and the block then moves on by itself. When no application image is left, it tries the factory image. A successful load puts the block in user mode.

In user mode, an active-low reconfigure input restarts the whole sequence. An update request does the same but names the image to load. The flash read port and the loader port are both request/acknowledge handshakes. A request is held, with a stable address, until the other side answers.

Top module: `boot_image_sel`

## Requirements
- R1: After reset, flash reads probe the record copies at byte offsets 0x000000, 0x080000, 0x100000 and 0x180000, in that order. The first copy whose word at offset +0 equals 0x5A1EC0DE is used. The record holds the factory image address at +4 and pointer entry i (i = 0..7) at +8+4*i. A flash request holds its address until it is acknowledged.
- R2: If none of the four copies carries the signature, the block raises the error flag. It issues no load request and no status pulse.
- R3: If the force-factory input is high when the factory word is read, the block loads the factory address directly. It reads no pointer entry.
- R4: Pointer entries are read and tried from index 7 down to index 0. An entry of 0xFFFFFFFF is empty and is skipped without a load request.
- R5: After a failed load, the block moves to the next lower pointer without any external request. Each failure drives the status output low for exactly 4 cycles. No load request is active during that pulse, and the pulse ends before the next attempt begins.
- R6: Once every application entry has failed or is empty, the block requests a load of the factory address.
- R7: A load reported done raises the user-mode flag. While the flag is high, the block makes no flash or load request.
- R8: Driving the reconfigure input low in user mode clears the user-mode flag and restarts probing at offset 0.
- R9: An update request in user mode captures a target address and restarts probing, with the reconfigure input left high. After the record is found, the block loads the target. If the target fails, it pulses status and then tries the factory image.
- R10: A failed factory load gives one status pulse and then a latched error flag. Only reset clears the flag, and reconfigure has no effect while it is set.
- R11: Reconfigure and update requests are ignored while a load request is outstanding. The load address stays stable until the loader answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| force_factory_i | input | 1 | Load factory image directly when high |
| reconfig_n_i | input | 1 | Active-low reconfigure request, honoured in user mode |
| upd_req_i | input | 1 | Update request, honoured in user mode |
| upd_addr_i | input | 32 | Target image address for an update |
| flash_req_o | output | 1 | Flash word read request |
| flash_addr_o | output | 32 | Flash byte address of the read |
| flash_ack_i | input | 1 | Flash read acknowledge, data valid |
| flash_data_i | input | 32 | Flash read data |
| ld_req_o | output | 1 | Image load request |
| ld_addr_o | output | 32 | Image address to load |
| ld_done_i | input | 1 | Loader reports success |
| ld_fail_i | input | 1 | Loader reports failure |
| status_n_o | output | 1 | Active-low failure pulse |
| user_mode_o | output | 1 | Device in user mode |
| error_o | output | 1 | Latched terminal error |

## Verification
A wrong record base or a wrong pointer index shows up on the very next flash read as a wrong address. A stuck or miscounted pointer index shows up as a load of the wrong image, or as a load where an empty entry should have been skipped. The bench logs every flash read, load request, status pulse length, user-mode entry and error entry in order. It compares that stream against the sequence predicted from the flash contents and the loader outcomes, so a divergence is reported at the first event that differs. A request that should have been ignored shows up as an unexpected event in the stream.

// File: rtl/boot_image_sel.sv
module boot_image_sel #(
  parameter int          AW          = 32,
  parameter int          N_COPIES    = 4,
  parameter logic [31:0] COPY_STRIDE = 32'h0008_0000,
  parameter int          N_PTRS      = 8,
  parameter logic [31:0] SIGNATURE   = 32'h5A1E_C0DE,
  parameter int          PULSE_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          force_factory_i,
  input  logic          reconfig_n_i,
  input  logic          upd_req_i,
  input  logic [AW-1:0] upd_addr_i,
  output logic          flash_req_o,
  output logic [AW-1:0] flash_addr_o,
  input  logic          flash_ack_i,
  input  logic [AW-1:0] flash_data_i,
  output logic          ld_req_o,
  output logic [AW-1:0] ld_addr_o,
  input  logic          ld_done_i,
  input  logic          ld_fail_i,
  output logic          status_n_o,
  output logic          user_mode_o,
  output logic          error_o
);
  localparam int CW = (N_COPIES > 1) ? $clog2(N_COPIES) : 1;
  localparam int IW = (N_PTRS > 1) ? $clog2(N_PTRS) : 1;
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [AW-1:0] EMPTY = '1;

  typedef enum logic [2:0] {ST_PROBE, ST_FACT, ST_PTR, ST_LOAD, ST_PULSE, ST_USER, ST_ERR} st_t;
  typedef enum logic [1:0] {K_APP, K_FACT, K_UPD} kind_t;

  st_t           st;
  kind_t         kind;
  logic [CW-1:0] copy;
  logic [IW-1:0] idx;
  logic [PW-1:0] pcnt;
  logic [AW-1:0] base, fact_addr, tgt, upd_addr;
  logic          upd_pend;

  always_comb begin
    case (st)
      ST_FACT: flash_addr_o = base + AW'(4);
      ST_PTR:  flash_addr_o = base + AW'(8) + (AW'(idx) << 2);
      default: flash_addr_o = AW'(copy) * AW'(COPY_STRIDE);
    endcase
  end

  assign flash_req_o = (st == ST_PROBE) || (st == ST_FACT) || (st == ST_PTR);
  assign ld_req_o    = (st == ST_LOAD);
  assign ld_addr_o   = tgt;
  assign status_n_o  = (st != ST_PULSE);
  assign user_mode_o = (st == ST_USER);
  assign error_o     = (st == ST_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PROBE;
      kind      <= K_APP;
      copy      <= '0;
      idx       <= '0;
      pcnt      <= '0;
      base      <= '0;
      fact_addr <= '0;
      tgt       <= '0;
      upd_addr  <= '0;
      upd_pend  <= 1'b0;
    end else begin
      case (st)
        ST_PROBE: if (flash_ack_i) begin
          if (flash_data_i == SIGNATURE) begin
            base <= flash_addr_o;
            st   <= ST_FACT;
          end else if (copy == CW'(N_COPIES - 1)) begin
            st <= ST_ERR;
          end else begin
            copy <= copy + 1'b1;
          end
        end
        ST_FACT: if (flash_ack_i) begin
          fact_addr <= flash_data_i;
          if (upd_pend) begin
            tgt      <= upd_addr;
            kind     <= K_UPD;
            upd_pend <= 1'b0;
            st       <= ST_LOAD;
          end else if (force_factory_i) begin
            tgt  <= flash_data_i;
            kind <= K_FACT;
            st   <= ST_LOAD;
          end else begin
            idx <= IW'(N_PTRS - 1);
            st  <= ST_PTR;
          end
        end
        ST_PTR: if (flash_ack_i) begin
          if (flash_data_i != EMPTY) begin
            tgt  <= flash_data_i;
            kind <= K_APP;
            st   <= ST_LOAD;
          end else if (idx == '0) begin
            tgt  <= fact_addr;
            kind <= K_FACT;
            st   <= ST_LOAD;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        ST_LOAD: begin
          if (ld_done_i) st <= ST_USER;
          else if (ld_fail_i) begin
            pcnt <= '0;
            st   <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (pcnt == PW'(PULSE_CYC - 1)) begin
            if (kind == K_FACT) st <= ST_ERR;
            else if (kind == K_APP && idx != '0) begin
              idx <= idx - 1'b1;
              st  <= ST_PTR;
            end else begin
              tgt  <= fact_addr;
              kind <= K_FACT;
              st   <= ST_LOAD;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_USER: begin
          if (!reconfig_n_i) begin
            copy <= '0;
            st   <= ST_PROBE;
          end else if (upd_req_i) begin
            upd_pend <= 1'b1;
            upd_addr <= upd_addr_i;
            copy     <= '0;
            st       <= ST_PROBE;
          end
        end
        default: st <= ST_ERR;
      endcase
    end
  end

  a_r1_flash_held: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req_o && !flash_ack_i |=> flash_req_o && $stable(flash_addr_o));
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_n_o) |=> !status_n_o);
  a_r5_no_load_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !status_n_o |-> !ld_req_o);
  a_r7_user_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_mode_o) |-> $past(ld_done_i));
  a_r7_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode_o |-> !ld_req_o && !flash_req_o);
  a_r10_error_latched: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o && !ld_req_o && status_n_o);
  a_r11_load_held: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req_o && !ld_done_i && !ld_fail_i |=> ld_req_o && $stable(ld_addr_o));
endmodule

// File: tb/sim_boot_image_sel.sv
module sim_boot_image_sel;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        force_factory_i, reconfig_n_i, upd_req_i;
  logic [31:0] upd_addr_i;
  logic        flash_req_o, flash_ack_i;
  logic [31:0] flash_addr_o, flash_data_i;
  logic        ld_req_o, ld_done_i, ld_fail_i;
  logic [31:0] ld_addr_o;
  logic        status_n_o, user_mode_o, error_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_image_sel u0 (
    .clk(clk), .rst_n(rst_n), .force_factory_i(force_factory_i),
    .reconfig_n_i(reconfig_n_i), .upd_req_i(upd_req_i), .upd_addr_i(upd_addr_i),
    .flash_req_o(flash_req_o), .flash_addr_o(flash_addr_o), .flash_ack_i(flash_ack_i),
    .flash_data_i(flash_data_i), .ld_req_o(ld_req_o), .ld_addr_o(ld_addr_o),
    .ld_done_i(ld_done_i), .ld_fail_i(ld_fail_i), .status_n_o(status_n_o),
    .user_mode_o(user_mode_o), .error_o(error_o)
  );

  // event kinds: 1 flash read, 2 load request, 3 status pulse (value = length), 4 user mode, 5 error
  logic [35:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] fmem[logic [31:0]];
  bit          ok_tab[logic [31:0]];
  int checks = 0, fails = 0, ld_cnt = 0, low_cnt = 0;
  bit prev_user = 0, prev_err = 0, finished = 0;

  function automatic void push(int t, logic [31:0] v, string tag);
    exp_q.push_back({t[3:0], v});
    tag_q.push_back(tag);
  endfunction

  function automatic void chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void note(int t, logic [31:0] v);
    logic [35:0] e;
    string tg;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL unexpected event (R11/R10) actual=%h expected=none", {t[3:0], v});
    end else begin
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk(tg, {t[3:0], v}, e);
    end
  endfunction

  function automatic logic [31:0] rd(logic [31:0] a);
    return fmem.exists(a) ? fmem[a] : 32'hFFFF_FFFF;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      flash_ack_i <= 1'b0; ld_done_i <= 1'b0; ld_fail_i <= 1'b0;
      ld_cnt = 0; low_cnt = 0; prev_user = 0; prev_err = 0;
    end else begin
      if (!status_n_o) low_cnt++;
      else if (low_cnt != 0) begin note(3, low_cnt); low_cnt = 0; end
      if (flash_req_o && !flash_ack_i) begin
        note(1, flash_addr_o);
        flash_data_i <= rd(flash_addr_o);
        flash_ack_i <= 1'b1;
      end else flash_ack_i <= 1'b0;
      if (ld_done_i || ld_fail_i) begin
        ld_done_i <= 1'b0; ld_fail_i <= 1'b0;
      end else if (ld_cnt > 1) ld_cnt--;
      else if (ld_cnt == 1) begin
        ld_cnt = 0;
        if (ok_tab.exists(ld_addr_o) && ok_tab[ld_addr_o]) ld_done_i <= 1'b1;
        else ld_fail_i <= 1'b1;
      end else if (ld_req_o) begin
        ld_cnt = 3;
        note(2, ld_addr_o);
      end
      if (user_mode_o && !prev_user) note(4, 0);
      prev_user = user_mode_o;
      if (error_o && !prev_err) note(5, 0);
      prev_err = error_o;
    end
  end

  task automatic wait_idle(string tag);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(tag, 36'(exp_q.size()), 36'd0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic reconfig_pulse();
    @(negedge clk) reconfig_n_i = 1'b0;
    @(negedge clk) reconfig_n_i = 1'b1;
  endtask

  task automatic push_decision(string tag);
    push(1, 32'h0000_0000, "R1");
    push(1, 32'h0008_0000, "R1");
    push(1, 32'h0008_0004, tag);
  endtask

  task automatic push_empty_tail();
    for (int i = 7; i >= 3; i--) push(1, 32'h0008_0008 + 4 * i, "R4");
  endtask

  initial begin
    rst_n = 1'b0; force_factory_i = 1'b0; reconfig_n_i = 1'b1;
    upd_req_i = 1'b0; upd_addr_i = '0;
    fmem[32'h0008_0000] = 32'h5A1E_C0DE;
    fmem[32'h0008_0004] = 32'h0010_0000;
    fmem[32'h0008_0008] = 32'h0020_0000;
    fmem[32'h0008_000C] = 32'h0030_0000;
    fmem[32'h0008_0010] = 32'h0040_0000;
    ok_tab[32'h0040_0000] = 0;
    ok_tab[32'h0030_0000] = 1;
    ok_tab[32'h0010_0000] = 1;
    ok_tab[32'h0050_0000] = 1;
    repeat (3) @(negedge clk);
    chk("R5 reset status", 36'(status_n_o), 36'd1);
    chk("R7 reset user", 36'(user_mode_o), 36'd0);
    chk("R10 reset error", 36'(error_o), 36'd0);

    // R1 R4 R5 R7: second copy valid, top pointers empty, first tried image fails
    push_decision("R1");
    push_empty_tail();
    push(1, 32'h0008_0010, "R4");
    push(2, 32'h0040_0000, "R4");
    push(3, 4, "R5");
    push(1, 32'h0008_000C, "R5");
    push(2, 32'h0030_0000, "R5");
    push(4, 0, "R7");
    rst_n = 1'b1;
    wait_idle("R7 scenario drained");

    // R8 R6 R11: reconfigure, all application images fail, requests during load ignored
    ok_tab[32'h0030_0000] = 0;
    ok_tab[32'h0020_0000] = 0;
    push_decision("R8");
    push_empty_tail();
    push(1, 32'h0008_0010, "R8");
    push(2, 32'h0040_0000, "R8");
    push(3, 4, "R5");
    push(1, 32'h0008_000C, "R5");
    push(2, 32'h0030_0000, "R11");
    push(3, 4, "R5");
    push(1, 32'h0008_0008, "R5");
    push(2, 32'h0020_0000, "R5");
    push(3, 4, "R5");
    push(2, 32'h0010_0000, "R6");
    push(4, 0, "R6");
    reconfig_pulse();
    do @(negedge clk); while (!ld_req_o);
    reconfig_n_i = 1'b0; upd_req_i = 1'b1; upd_addr_i = 32'h0070_0000;
    @(negedge clk);
    reconfig_n_i = 1'b1; upd_req_i = 1'b0;
    wait_idle("R11 scenario drained");

    // R9: update to a good target
    push_decision("R9");
    push(2, 32'h0050_0000, "R9");
    push(4, 0, "R9");
    @(negedge clk) begin upd_req_i = 1'b1; upd_addr_i = 32'h0050_0000; end
    @(negedge clk) upd_req_i = 1'b0;
    chk("R8 user mode cleared", 36'(user_mode_o), 36'd0);
    wait_idle("R9 scenario drained");

    // R3: force factory
    force_factory_i = 1'b1;
    push_decision("R3");
    push(2, 32'h0010_0000, "R3");
    push(4, 0, "R3");
    reconfig_pulse();
    wait_idle("R3 scenario drained");
    force_factory_i = 1'b0;

    // R9 R10: failing update target, then failing factory
    ok_tab[32'h0010_0000] = 0;
    push_decision("R9");
    push(2, 32'h0060_0000, "R9");
    push(3, 4, "R9");
    push(2, 32'h0010_0000, "R9");
    push(3, 4, "R10");
    push(5, 0, "R10");
    @(negedge clk) begin upd_req_i = 1'b1; upd_addr_i = 32'h0060_0000; end
    @(negedge clk) upd_req_i = 1'b0;
    wait_idle("R10 scenario drained");
    reconfig_pulse();
    repeat (40) @(negedge clk);
    chk("R10 error held", 36'(error_o), 36'd1);
    chk("R10 no user mode", 36'(user_mode_o), 36'd0);

    // R2: no valid copy
    rst_n = 1'b0;
    fmem[32'h0008_0000] = 32'h0;
    push(1, 32'h0000_0000, "R2");
    push(1, 32'h0008_0000, "R2");
    push(1, 32'h0010_0000, "R2");
    push(1, 32'h0018_0000, "R2");
    push(5, 0, "R2");
    repeat (2) @(negedge clk);
    chk("R10 reset clears error", 36'(error_o), 36'd0);
    rst_n = 1'b1;
    wait_idle("R2 scenario drained");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule